// File: doc/BRIEF.md
# Two-Channel Packet Interleaving Arbiter

This block merges the packet streams of two independent sources into one interleaved stream for a transmit MAC. Each source presents beats with valid, ready, start and end delimiters, an error flag and an empty-byte count. Valid bytes sit in the most significant byte lanes, and the count of unused low lanes may be nonzero on any beat, including beats in the middle of a packet. Each output beat carries the source's data, delimiters, error flag and empty count without change, together with a tag that names the source channel.

A channel is accepted only when its enable bit is set and the receive calendar permits it. A force-transmit input overrides the calendar. A channel that is not accepted keeps its ready high and its beats are dropped, so its source never stalls. When a packet is under way, the arbiter stays on that channel until the end of the packet or until a burst of a fixed number of beats is complete. At each such switch point, priority passes to the other channel. The output stage is a register with its own ready input, and it backpressures both sources while it is stalled.

Top module: `pkt_interleave2`

## Requirements
- R1: The effective acceptance of channel i is enable[i] AND (calendar[i] OR force_tx). A channel that is not accepted has in_ready[i] held at 1, and none of its beats ever appear at the output.
- R2: With force_tx low and a calendar value of 0, no beat is forwarded. With force_tx high, enabled channels are forwarded whatever the calendar value is.
- R3: Beats from each accepted channel leave in their arrival order. Data, sop, eop, err and empty are unchanged, and out_chan equals the source index (0 or 1).
- R4: A nonzero empty count on a beat that is not end-of-packet is forwarded unchanged.
- R5: Once a channel has sent a beat without eop, the output switches to the other channel only after an eop beat or after BURST_MAX (default 8) consecutive beats from that channel.
- R6: After reset, channel 0 has priority. At every switch point, priority passes to the other channel, so two channels that always have data alternate in runs of BURST_MAX beats, starting with channel 0.
- R7: While out_valid is high and out_ready is low, every output field stays stable on the next cycle.
- R8: While in reset, out_valid is 0.
- R9: In any cycle, at most one accepted channel sees ready. No accepted channel sees ready while the output is stalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ch_en | input | 2 | Per-channel enable bits |
| cal_permit | input | 2 | Per-channel flow-control permit from the receive calendar |
| force_tx | input | 1 | Ignore the calendar permits |
| in_valid | input | 2 | Per-channel beat valid |
| in_ready | output | 2 | Per-channel ready |
| in_data | input | 2*DATA_W | Channel data, channel 0 in the low slice |
| in_sop | input | 2 | Start of packet |
| in_eop | input | 2 | End of packet |
| in_err | input | 2 | Packet error, meaningful on eop |
| in_empty | input | 2*EMPTY_W | Count of unused low byte lanes |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream ready |
| out_data | output | DATA_W | Output data |
| out_sop | output | 1 | Output start of packet |
| out_eop | output | 1 | Output end of packet |
| out_err | output | 1 | Output error flag |
| out_empty | output | EMPTY_W | Output empty count |
| out_chan | output | 1 | Source channel tag |

## Verification
The assertions assume that each source holds its beat stable until it is accepted, and that packets are well formed, with sop on the first beat and eop on the last. The burst-switch property also assumes that enables and calendar permits do not drop in the middle of a burst. The stimulus keeps each beat until its handshake completes and generates packets with whole delimiters. It checks the switch rule only in phases where acceptance is held steady. Calendar and force values vary from cycle to cycle only in a separate phase where that check is turned off.

// File: rtl/pm_pkg.sv
package pm_pkg;
   localparam int unsigned NCH = 2;
   typedef logic [$clog2(NCH)-1:0] chan_t;

   function automatic chan_t other_chan(input chan_t c);
      return ~c;
   endfunction
endpackage

// File: rtl/pm_gate.sv
module pm_gate
   import pm_pkg::*;
(
   input  logic [NCH-1:0] ch_en,
   input  logic [NCH-1:0] cal_permit,
   input  logic           force_tx,
   input  logic [NCH-1:0] grant_oh,
   input  logic           load,
   output logic [NCH-1:0] eff_en,
   output logic [NCH-1:0] in_ready
);
   generate
      for (genvar i = 0; i < NCH; i++) begin : g_ch
         assign eff_en[i]   = ch_en[i] & (cal_permit[i] | force_tx);
         // a blocked channel drains freely so its source never stalls
         assign in_ready[i] = eff_en[i] ? (load & grant_oh[i]) : 1'b1;
      end
   endgenerate
endmodule

// File: rtl/pm_sched.sv
module pm_sched
   import pm_pkg::*;
#(
   parameter int unsigned BURST_MAX = 8
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NCH-1:0] eff_en,
   input  logic [NCH-1:0] in_valid,
   input  logic [NCH-1:0] in_eop,
   input  logic           take,
   output logic           grant_vld,
   output chan_t          grant_idx
);
   localparam int unsigned CNT_W = $clog2(BURST_MAX);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(BURST_MAX - 1);

   logic [NCH-1:0] req;
   chan_t          cur_q, prio_q;
   logic           locked_q;
   logic [CNT_W-1:0] cnt_q;
   logic           fire, boundary;

   assign req = in_valid & eff_en;

   always_comb begin
      grant_vld = 1'b0;
      grant_idx = prio_q;
      if (locked_q && eff_en[cur_q]) begin
         grant_idx = cur_q;
         grant_vld = in_valid[cur_q];
      end else if (req[prio_q]) begin
         grant_idx = prio_q;
         grant_vld = 1'b1;
      end else if (req[other_chan(prio_q)]) begin
         grant_idx = other_chan(prio_q);
         grant_vld = 1'b1;
      end
   end

   assign fire     = take & grant_vld;
   assign boundary = in_eop[grant_idx] | (cnt_q == LAST);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur_q    <= '0;
         prio_q   <= '0;
         locked_q <= 1'b0;
         cnt_q    <= '0;
      end else if (fire) begin
         cur_q <= grant_idx;
         if (boundary) begin
            locked_q <= 1'b0;
            cnt_q    <= '0;
            prio_q   <= other_chan(grant_idx);
         end else begin
            locked_q <= 1'b1;
            cnt_q    <= cnt_q + 1'b1;
         end
      end else if (locked_q && !eff_en[cur_q]) begin
         locked_q <= 1'b0;
         cnt_q    <= '0;
      end
   end

   // R5: a mid-burst beat is never followed by a beat from the other channel
   a_r5_no_early_switch: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && !in_eop[grant_idx] && cnt_q != LAST && eff_en[grant_idx])
      |=> !(fire && eff_en[$past(grant_idx)] && grant_idx != $past(grant_idx)));
endmodule

// File: rtl/pm_outreg.sv
module pm_outreg
   import pm_pkg::*;
#(
   parameter int unsigned DATA_W  = 64,
   parameter int unsigned EMPTY_W = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sel_vld,
   input  logic [DATA_W-1:0]  sel_data,
   input  logic               sel_sop,
   input  logic               sel_eop,
   input  logic               sel_err,
   input  logic [EMPTY_W-1:0] sel_empty,
   input  chan_t              sel_chan,
   input  logic               out_ready,
   output logic               load,
   output logic               out_valid,
   output logic [DATA_W-1:0]  out_data,
   output logic               out_sop,
   output logic               out_eop,
   output logic               out_err,
   output logic [EMPTY_W-1:0] out_empty,
   output chan_t              out_chan
);
   assign load = !out_valid | out_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
         out_sop   <= 1'b0;
         out_eop   <= 1'b0;
         out_err   <= 1'b0;
         out_empty <= '0;
         out_chan  <= '0;
      end else if (load) begin
         out_valid <= sel_vld;
         if (sel_vld) begin
            out_data  <= sel_data;
            out_sop   <= sel_sop;
            out_eop   <= sel_eop;
            out_err   <= sel_err;
            out_empty <= sel_empty;
            out_chan  <= sel_chan;
         end
      end
   end

   a_r7_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_chan)
         && $stable(out_sop) && $stable(out_eop) && $stable(out_err) && $stable(out_empty)));
endmodule

// File: rtl/pkt_interleave2.sv
module pkt_interleave2
   import pm_pkg::*;
#(
   parameter int unsigned DATA_W    = 64,
   parameter int unsigned BURST_MAX = 8,
   localparam int unsigned BYTES    = DATA_W / 8,
   localparam int unsigned EMPTY_W  = $clog2(BYTES)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [1:0]             ch_en,
   input  logic [1:0]             cal_permit,
   input  logic                   force_tx,
   input  logic [1:0]             in_valid,
   output logic [1:0]             in_ready,
   input  logic [2*DATA_W-1:0]    in_data,
   input  logic [1:0]             in_sop,
   input  logic [1:0]             in_eop,
   input  logic [1:0]             in_err,
   input  logic [2*EMPTY_W-1:0]   in_empty,
   output logic                   out_valid,
   input  logic                   out_ready,
   output logic [DATA_W-1:0]      out_data,
   output logic                   out_sop,
   output logic                   out_eop,
   output logic                   out_err,
   output logic [EMPTY_W-1:0]     out_empty,
   output logic                   out_chan
);
   generate
      if (DATA_W % 8 != 0 || DATA_W < 16) begin : g_bad_width
         $error("DATA_W must be a multiple of 8 and at least 16");
      end
      if (BURST_MAX < 2) begin : g_bad_burst
         $error("BURST_MAX must be at least 2");
      end
   endgenerate

   logic [NCH-1:0] eff_en, grant_oh;
   logic           grant_vld, load;
   chan_t          grant_idx, chan_q;

   generate
      for (genvar i = 0; i < NCH; i++) begin : g_oh
         assign grant_oh[i] = grant_vld && (grant_idx == chan_t'(i));
      end
   endgenerate

   pm_gate u_gate (
      .ch_en(ch_en), .cal_permit(cal_permit), .force_tx(force_tx),
      .grant_oh(grant_oh), .load(load), .eff_en(eff_en), .in_ready(in_ready)
   );

   pm_sched #(.BURST_MAX(BURST_MAX)) u_sched (
      .clk(clk), .rst_n(rst_n), .eff_en(eff_en), .in_valid(in_valid),
      .in_eop(in_eop), .take(load), .grant_vld(grant_vld), .grant_idx(grant_idx)
   );

   pm_outreg #(.DATA_W(DATA_W), .EMPTY_W(EMPTY_W)) u_out (
      .clk(clk), .rst_n(rst_n), .sel_vld(grant_vld),
      .sel_data(in_data[int'(grant_idx)*DATA_W +: DATA_W]),
      .sel_sop(in_sop[grant_idx]), .sel_eop(in_eop[grant_idx]),
      .sel_err(in_err[grant_idx]),
      .sel_empty(in_empty[int'(grant_idx)*EMPTY_W +: EMPTY_W]),
      .sel_chan(grant_idx), .out_ready(out_ready), .load(load),
      .out_valid(out_valid), .out_data(out_data), .out_sop(out_sop),
      .out_eop(out_eop), .out_err(out_err), .out_empty(out_empty), .out_chan(chan_q)
   );

   assign out_chan = chan_q[0];

   generate
      for (genvar i = 0; i < NCH; i++) begin : g_chk
         a_r1_off_ready: assert property (@(posedge clk) disable iff (!rst_n)
            !ch_en[i] |-> in_ready[i]);
      end
   endgenerate

   a_r9_single_ready: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(in_ready & eff_en) <= 1);

   a_r9_stall_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |-> ((in_ready & eff_en) == '0));

   a_r3_src_accepted: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_valid) |-> $past(|(in_valid & in_ready & eff_en)));
endmodule

// File: tb/pkt_interleave2_tb_top.sv
module pkt_interleave2_tb_top;
   localparam int DW = 64;
   localparam int EW = 3;
   localparam int BW = DW + 3 + EW;
   localparam int BURST = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [1:0] ch_en = 2'b11, cal_permit = 2'b11, in_valid = '0, in_ready;
   logic force_tx = 1'b0;
   logic [2*DW-1:0] in_data = '0;
   logic [1:0] in_sop = '0, in_eop = '0, in_err = '0;
   logic [2*EW-1:0] in_empty = '0;
   logic out_valid, out_ready = 1'b0, out_sop, out_eop, out_err, out_chan;
   logic [DW-1:0] out_data;
   logic [EW-1:0] out_empty;

   always #2 clk = ~clk;

   pkt_interleave2 #(.DATA_W(DW), .BURST_MAX(BURST)) dut_i (
      .clk(clk), .rst_n(rst_n), .ch_en(ch_en), .cal_permit(cal_permit),
      .force_tx(force_tx), .in_valid(in_valid), .in_ready(in_ready),
      .in_data(in_data), .in_sop(in_sop), .in_eop(in_eop), .in_err(in_err),
      .in_empty(in_empty), .out_valid(out_valid), .out_ready(out_ready),
      .out_data(out_data), .out_sop(out_sop), .out_eop(out_eop),
      .out_err(out_err), .out_empty(out_empty), .out_chan(out_chan)
   );

   int total = 0, fails = 0;
   logic [BW-1:0] q0[$], q1[$];
   logic [BW-1:0] beat[2];
   int left[2];
   bit pend[2], acc[2];
   int vprob, rprob, lenfix;
   bit cal_rand, force_rand, chk_sw, gen_new;
   bit prev_stall, have_last, last_eop;
   logic [BW:0] prev_out;
   int last_tag, run, mp_cnt;
   int tag_log[$];
   int out_cnt[2];

   task automatic chk(input bit ok, input string req, input logic [BW:0] act, input logic [BW:0] exp);
      total++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", total - fails, total);
   endtask

   function automatic logic [BW-1:0] out_beat();
      return {out_data, out_sop, out_eop, out_err, out_empty};
   endfunction

   task automatic next_beat(input int c);
      logic s, e, r;
      logic [EW-1:0] em;
      if (left[c] == 0) begin
         left[c] = (lenfix > 0) ? lenfix : int'($urandom_range(1, 14));
         s = 1'b1;
      end else s = 1'b0;
      e = (left[c] == 1);
      left[c]--;
      em = ($urandom_range(0, 3) == 0) ? EW'($urandom_range(1, 7)) : '0;
      r = e && ($urandom_range(0, 3) == 0);
      beat[c] = {$urandom, $urandom, s, e, r, em};
      pend[c] = 1'b1;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      in_valid = '0;
      q0.delete(); q1.delete(); tag_log.delete();
      for (int c = 0; c < 2; c++) begin left[c] = 0; pend[c] = 0; acc[c] = 0; out_cnt[c] = 0; end
      prev_stall = 0; have_last = 0; run = 0;
      repeat (3) @(negedge clk);
      chk(out_valid == 1'b0, "R8", out_valid, 0);
      rst_n = 1'b1;
   endtask

   task automatic cycles(input int n);
      for (int k = 0; k < n; k++) begin
         logic [1:0] eff;
         logic [BW-1:0] ob, ex;
         @(negedge clk);
         for (int c = 0; c < 2; c++) begin
            if (acc[c]) pend[c] = 0;
            if (!pend[c] && (gen_new || left[c] > 0) && $urandom_range(0, 99) < vprob)
               next_beat(c);
            in_valid[c] = pend[c] && ($urandom_range(0, 99) < vprob);
         end
         in_data  = {beat[1][BW-1:6], beat[0][BW-1:6]};
         in_sop   = {beat[1][5], beat[0][5]};
         in_eop   = {beat[1][4], beat[0][4]};
         in_err   = {beat[1][3], beat[0][3]};
         in_empty = {beat[1][2:0], beat[0][2:0]};
         out_ready = ($urandom_range(0, 99) < rprob);
         if (cal_rand) cal_permit = 2'($urandom);
         if (force_rand) force_tx = 1'($urandom);
         #1;
         if (prev_stall)
            chk(out_valid && {out_chan, out_beat()} == prev_out, "R7", {out_chan, out_beat()}, prev_out);
         eff = ch_en & (cal_permit | {2{force_tx}});
         if (out_valid && !out_ready)
            chk((in_ready & eff) == 0, "R9", in_ready, 0);
         chk($countones(in_ready & eff) <= 1, "R9", in_ready, eff);
         for (int c = 0; c < 2; c++) begin
            if (!eff[c]) chk(in_ready[c] == 1'b1, "R1", in_ready[c], 1);
            acc[c] = in_valid[c] && in_ready[c];
            if (acc[c] && eff[c]) begin
               if (c == 0) q0.push_back(beat[0]); else q1.push_back(beat[1]);
            end
         end
         if (out_valid && out_ready) begin
            int t;
            t = int'(out_chan);
            ob = out_beat();
            out_cnt[t]++;
            tag_log.push_back(t);
            if ((t == 0 && q0.size() == 0) || (t == 1 && q1.size() == 0))
               chk(0, "R1 R3", {out_chan, ob}, 0);
            else begin
               ex = (t == 0) ? q0.pop_front() : q1.pop_front();
               chk(ob == ex, "R3 R4", ob, ex);
               if (ob == ex && !ob[4] && ob[2:0] != 0) mp_cnt++;
            end
            if (chk_sw && have_last && t != last_tag)
               chk(last_eop || run == BURST, "R5", run, BURST);
            if (have_last && t == last_tag && !last_eop && run < BURST) run++;
            else run = 1;
            have_last = 1; last_tag = t; last_eop = ob[4];
         end
         prev_stall = out_valid && !out_ready;
         prev_out = {out_chan, out_beat()};
      end
   endtask

   task automatic drain();
      gen_new = 0; vprob = 100; rprob = 100; cal_rand = 0; force_rand = 0;
      force_tx = 1; cal_permit = 2'b11;
      cycles(80);
      chk(q0.size() == 0 && q1.size() == 0, "R3", q0.size() + q1.size(), 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++; total++;
      $display("FAIL watchdog expired actual=hung expected=done");
      summary();
      $finish;
   end

   initial begin
      gen_new = 1; lenfix = 0; cal_rand = 0; force_rand = 0; chk_sw = 1;
      mp_cnt = 0;

      // R6 and R5: both channels always busy with long packets
      ch_en = 2'b11; force_tx = 1; cal_permit = 2'b11; vprob = 100; rprob = 100; lenfix = 20;
      do_reset();
      cycles(24);
      for (int i = 0; i < 17; i++)
         chk(tag_log.size() > i && tag_log[i] == ((i / BURST) % 2), "R6",
             tag_log.size() > i ? tag_log[i] : -1, (i / BURST) % 2);
      drain();
      lenfix = 0;

      // R1: only channel 0 enabled (value 1)
      gen_new = 1; ch_en = 2'b01; force_tx = 1; vprob = 70; rprob = 80;
      do_reset();
      cycles(300);
      chk(out_cnt[1] == 0, "R1", out_cnt[1], 0);
      chk(out_cnt[0] > 0, "R1", out_cnt[0], 1);
      drain();

      // R2: calendar blocks everything without force
      gen_new = 1; ch_en = 2'b11; force_tx = 0; cal_permit = 2'b00; vprob = 80; rprob = 90;
      do_reset();
      cycles(150);
      chk(out_cnt[0] + out_cnt[1] == 0, "R2", out_cnt[0] + out_cnt[1], 0);
      force_tx = 1; have_last = 0;
      cycles(200);
      chk(out_cnt[0] > 0 && out_cnt[1] > 0, "R2", {out_cnt[1][15:0], out_cnt[0][15:0]}, 1);
      drain();

      // random calendar and force per cycle; switch rule not checked here
      gen_new = 1; chk_sw = 0; cal_rand = 1; force_rand = 1; vprob = 60; rprob = 60;
      do_reset();
      cycles(3000);
      drain();
      chk_sw = 1;

      // steady acceptance with backpressure, switch rule checked
      gen_new = 1; cal_permit = 2'b11; force_tx = 0; vprob = 75; rprob = 55;
      do_reset();
      cycles(4000);
      drain();
      chk(mp_cnt > 0, "R4", mp_cnt, 1);

      summary();
      $finish;
   end
endmodule